// File: doc/BRIEF.md
# Address-match breakpoint controller

This block is a single-channel breakpoint unit. It watches the bus cycles that the CPU and the other bus masters issue, compares each address with a programmed break address, and raises a level interrupt request toward an external interrupt controller when the programmed condition is met. Software programs the unit through a two-register read/write port. One register holds the break address. The other holds the configuration and a sticky match flag.

The watched condition can be an instruction fetch or a data access. A data access can be a read, a write or either, and it covers every address space, including stack traffic and branch-target reads. A mask code selects how many low address bits take no part in the compare. A master-select bit chooses which master is watched. A fetch condition only ever matches CPU fetches. For a fetch condition, the fetch address must be the first byte of the instruction. A fetch match is not reported when the instruction is fetched. It is held pending and reported just before that same instruction executes. The pending match is dropped if a different instruction executes first. Priority handling and vectoring take place downstream of this block.

Top module: `brkpt_unit`

## Requirements
- R1: After reset, both registers read as zero, the match flag is clear and `irq_req` is low.
- R2: With `reg_sel`=0 the port accesses the break address (low ADDR_W bits of the data word). With `reg_sel`=1 it accesses the control word: bit 0 enable, bits 2:1 condition, bits 5:3 mask code, bit 6 master select, bit 7 match flag. Writes take effect on the next clock and reads are combinational.
- R3: `irq_req` is high exactly while the match flag and the enable bit are both 1. A match with enable 0 still sets the flag.
- R4: Condition 01 matches only reads (`bus_kind`=01). Condition 10 matches only writes (`bus_kind`=10). Condition 11 matches both. A fetch cycle (`bus_kind`=00) never satisfies a data condition.
- R5: A data condition matches only cycles whose `bus_master` equals the master-select bit (0 is the CPU, 1 is the other master).
- R6: Mask code 001 ignores address bit 0, 010 ignores bits 1:0, 011 ignores bits 3:0, 100 ignores bits 7:0 and 101 ignores bits 11:0. Codes 000, 110 and 111 compare every bit.
- R7: With condition 00, a matching CPU fetch does not set the flag. The flag is set one clock after `exec_valid` presents the same address as the fetch.
- R8: With condition 00, a fetch never matches when the master-select bit is 1, and a fetch issued by `bus_master`=1 never matches.
- R9: A pending fetch match is discarded when `exec_valid` presents a different address before the matching one.
- R10: The flag is sticky. It is cleared only by writing control bit 7 as 0 after a control read that returned the flag as 1. A write without that read leaves the flag set, and writing bit 7 as 1 never sets it.
- R11: When a match and a clear fall in the same clock, the flag stays set.
- R12: A data match sets the flag, and raises the request if enabled, one clock after the matching bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 break address, 1 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_master | input | 1 | Issuing master: 0 CPU, 1 other |
| bus_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| exec_valid | input | 1 | An instruction is about to execute |
| exec_addr | input | ADDR_W | Address of that instruction's first byte |
| irq_req | output | 1 | Level interrupt request |

## Verification
Every result appears one clock after its cause. A register write shows on the next read. A matching data cycle raises the flag and request one edge after it is presented. A fetch break shows one edge after the matching execute strobe and never after the fetch alone. Read data is combinational and is taken shortly after the falling edge at which the read is driven. The bench drives each stimulus at a falling edge and holds it for one full period. It samples the request at the next falling edge, which lies half a period after the single register stage that the result passes through.

// File: rtl/brkpt_pkg.sv
// Shared types for the breakpoint unit.
// Assumes an 8-bit control word whose layout is fixed by the field order below.
package brkpt_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_NONE  = 2'b11
    } bus_kind_e;

    typedef enum logic [1:0] {
        COND_FETCH = 2'b00,
        COND_READ  = 2'b01,
        COND_WRITE = 2'b10,
        COND_ANY   = 2'b11
    } cond_e;

    // Control word, MSB first: flag, master select, mask code, condition, enable
    typedef struct packed {
        logic       flag;
        logic       msel;
        logic [2:0] mask;
        cond_e      cond;
        logic       en;
    } ctrl_t;

    // Number of low address bits that a mask code excludes from the compare
    function automatic logic [3:0] ignore_count(input logic [2:0] code);
        case (code)
            3'd1:    ignore_count = 4'd1;
            3'd2:    ignore_count = 4'd2;
            3'd3:    ignore_count = 4'd4;
            3'd4:    ignore_count = 4'd8;
            3'd5:    ignore_count = 4'd12;
            default: ignore_count = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/brkpt_regs.sv
// Register file of the breakpoint unit: break address, configuration and sticky flag.
// Assumes REG_W > ADDR_W >= CTRL_W. The flag clear is a read-then-write sequence,
// and a simultaneous hit overrides the clear.
module brkpt_regs
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              hit,
    output logic [ADDR_W-1:0] brk_addr,
    output ctrl_t             ctrl
);

    localparam int CFG_W = CTRL_W - 1;

    logic [ADDR_W-1:0] addr_q;
    logic [CFG_W-1:0]  cfg_q;
    logic              flag_q;
    logic              armed_q;
    logic              ctrl_wr;
    logic              ctrl_rd;
    logic              clr_req;

    assign ctrl_wr = reg_wr && reg_sel;
    assign ctrl_rd = reg_rd && reg_sel;
    assign clr_req = ctrl_wr && armed_q && !reg_wdata[CTRL_W-1];

    // Break address register
    always_ff @(posedge clk) begin
        if (!rst_n)                  addr_q <= '0;
        else if (reg_wr && !reg_sel) addr_q <= reg_wdata[ADDR_W-1:0];
    end

    // Configuration bits below the flag
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (ctrl_wr) cfg_q <= reg_wdata[CFG_W-1:0];
    end

    // Clear arming: set by reading the flag as 1, spent by any control write
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (ctrl_wr)          armed_q <= 1'b0;
        else if (ctrl_rd && flag_q) armed_q <= 1'b1;
    end

    // Sticky match flag; a hit wins over a clear in the same clock
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    // Combinational read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) reg_rdata[CTRL_W-1:0] = {flag_q, cfg_q};
        else         reg_rdata[ADDR_W-1:0] = addr_q;
    end

    assign brk_addr = addr_q;
    assign ctrl     = ctrl_t'({flag_q, cfg_q});

    // Upper write-data bits carry nothing
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[REG_W-1:ADDR_W];

endmodule

// File: rtl/brkpt_addr_match.sv
// Masked address comparator: each bit below the ignore count is a don't-care.
// Assumes ADDR_W >= 12 so that every mask code fits inside the address.
module brkpt_addr_match
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        mask_code,
    output logic              match
);

    logic [3:0]        ign_cnt;
    logic [ADDR_W-1:0] care;

    assign ign_cnt = ignore_count(mask_code);

    // One care bit per address bit, active above the ignored range
    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
        if (i < 12) begin : g_low
            assign care[i] = (ign_cnt <= 4'(i));
        end else begin : g_high
            assign care[i] = 1'b1;
        end
    end

    // Compare only the cared-for bits
    assign match = ~|((brk_addr ^ bus_addr) & care);

endmodule

// File: rtl/brkpt_fetch_track.sv
// Pending-fetch tracker: remembers the address of a matching fetch and reports a
// hit when that instruction is announced for execution. Any other executed address
// drops the pending match, and losing the fetch configuration drops it too.
module brkpt_fetch_track #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_cfg,
    input  logic              fetch_seen,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              exec_valid,
    input  logic [ADDR_W-1:0] exec_addr,
    output logic              fetch_hit,
    output logic              pend
);

    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;

    // A hit needs a live pending match whose address is the one executing
    assign fetch_hit = pend_q && fetch_cfg && exec_valid && (exec_addr == pend_addr_q);

    // Pending state: a new fetch replaces; execution or config change retires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (fetch_seen) begin
            pend_q      <= 1'b1;
            pend_addr_q <= fetch_addr;
        end else if (exec_valid || !fetch_cfg) begin
            pend_q      <= 1'b0;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/brkpt_unit.sv
// Top of the single-channel breakpoint unit. It qualifies bus cycles against the
// programmed condition, master and masked address, and drives a level request
// from the sticky flag and the enable bit. Assumes one bus cycle per clock at most.
module brkpt_unit
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_master,
    input  logic [1:0]        bus_kind,
    input  logic              exec_valid,
    input  logic [ADDR_W-1:0] exec_addr,
    output logic              irq_req
);

    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] brk_addr;
    logic              addr_hit;
    logic              kind_ok;
    logic              data_hit;
    logic              fetch_cfg;
    logic              fetch_seen;
    logic              fetch_hit;
    logic              pend;
    logic              hit_any;
    bus_kind_e         kind;

    assign kind = bus_kind_e'(bus_kind);

    brkpt_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit       (hit_any),
        .brk_addr  (brk_addr),
        .ctrl      (ctrl_q)
    );

    brkpt_addr_match #(.ADDR_W(ADDR_W)) cmp_i (
        .brk_addr  (brk_addr),
        .bus_addr  (bus_addr),
        .mask_code (ctrl_q.mask),
        .match     (addr_hit)
    );

    // Access-kind qualification for the data conditions
    always_comb begin
        case (ctrl_q.cond)
            COND_READ:  kind_ok = (kind == KIND_READ);
            COND_WRITE: kind_ok = (kind == KIND_WRITE);
            COND_ANY:   kind_ok = (kind == KIND_READ) || (kind == KIND_WRITE);
            default:    kind_ok = 1'b0;
        endcase
    end

    assign data_hit   = bus_valid && kind_ok && (bus_master == ctrl_q.msel) && addr_hit;

    // A fetch condition is only meaningful with the CPU selected
    assign fetch_cfg  = (ctrl_q.cond == COND_FETCH) && !ctrl_q.msel;
    assign fetch_seen = fetch_cfg && bus_valid && (kind == KIND_FETCH) &&
                        !bus_master && addr_hit;

    brkpt_fetch_track #(.ADDR_W(ADDR_W)) trk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_cfg  (fetch_cfg),
        .fetch_seen (fetch_seen),
        .fetch_addr (bus_addr),
        .exec_valid (exec_valid),
        .exec_addr  (exec_addr),
        .fetch_hit  (fetch_hit),
        .pend       (pend)
    );

    assign hit_any = data_hit || fetch_hit;

    // Level request toward the interrupt controller
    assign irq_req = ctrl_q.flag && ctrl_q.en;

endmodule

// File: rtl/brkpt_unit_checker.sv
// Temporal checks on the breakpoint unit, attached to every instance by bind.
module brkpt_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic       wr_flag_bit,
    input logic       bus_valid,
    input logic       exec_valid,
    input logic       irq_req,
    input logic       flag,
    input logic       msel,
    input logic [1:0] cond,
    input logic       hit_any,
    input logic       pend
);

    // R3: the request can only rise after a bus cycle, an execute or a register write
    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(bus_valid || exec_valid || reg_wr));

    // R10: the flag falls only after a control write carrying bit 7 as 0
    assert_flag_clear_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(reg_wr && reg_sel && !wr_flag_bit));

    // R11: a hit always leaves the flag set, whatever else happens that clock
    assert_hit_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> flag);

    // R7: under a fetch condition the flag cannot rise without an execute strobe
    assert_fetch_waits_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 2'b00 && !exec_valid && !flag) |=> !flag);

    // R8: a fetch condition with the other master selected never matches
    assert_fetch_cpu_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 2'b00 && msel && !flag) |=> !flag);

    // R7: a pending fetch match only starts from a bus cycle
    assert_pend_from_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(bus_valid));

endmodule

bind brkpt_unit brkpt_unit_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_sel),
    .reg_wr      (reg_wr),
    .wr_flag_bit (reg_wdata[7]),
    .bus_valid   (bus_valid),
    .exec_valid  (exec_valid),
    .irq_req     (irq_req),
    .flag        (ctrl_q.flag),
    .msel        (ctrl_q.msel),
    .cond        (ctrl_q.cond),
    .hit_any     (hit_any),
    .pend        (pend)
);

// File: tb/brkpt_unit_tb_top.sv
// Directed bench for the breakpoint unit: one task per scenario, each checking itself.
module brkpt_unit_tb_top;

    localparam int ADDR_W = 24;
    localparam int REG_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_sel = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              bus_valid = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_master = 1'b0;
    logic [1:0]        bus_kind = 2'b11;
    logic              exec_valid = 1'b0;
    logic [ADDR_W-1:0] exec_addr = '0;
    logic              irq_req;

    int n_chk = 0;
    int n_err = 0;

    brkpt_unit #(.ADDR_W(ADDR_W), .REG_W(REG_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .bus_valid  (bus_valid),
        .bus_addr   (bus_addr),
        .bus_master (bus_master),
        .bus_kind   (bus_kind),
        .exec_valid (exec_valid),
        .exec_addr  (exec_addr),
        .irq_req    (irq_req)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] data);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 data = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus(input logic [23:0] a, input logic m, input logic [1:0] k);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_master = m; bus_kind = k;
        @(negedge clk);
        bus_valid = 1'b0; bus_kind = 2'b11;
    endtask

    task automatic exe(input logic [23:0] a);
        @(negedge clk);
        exec_valid = 1'b1; exec_addr = a;
        @(negedge clk);
        exec_valid = 1'b0;
    endtask

    // Proper clear sequence: read the flag as 1, then write bit 7 as 0
    task automatic clear_flag();
        logic [31:0] v;
        rd(1'b1, v);
        if (v[7]) wr(1'b1, v & 32'h7F);
    endtask

    // One bus cycle, then the request is compared one clock later
    task automatic probe(input string req, input logic [23:0] a, input logic m,
                         input logic [1:0] k, input logic exp);
        bus(a, m, k);
        check(req, {31'd0, irq_req}, {31'd0, exp});
        clear_flag();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq after reset", {31'd0, irq_req}, 32'd0);
        rd(1'b0, v); check("R1 address reg", v, 32'd0);
        rd(1'b1, v); check("R1 control reg", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(1'b0, 32'hFF12_345A);
        rd(1'b0, v); check("R2 address readback", v, 32'h0012_345A);
        wr(1'b1, 32'h7E);
        rd(1'b1, v); check("R2 control readback", v, 32'h7E);
        wr(1'b1, 32'h80);
        rd(1'b1, v); check("R10 bit7 write cannot set flag", v, 32'h00);
    endtask

    task automatic t_data_kinds();
        wr(1'b0, 32'h0000_1000);
        wr(1'b1, 32'h03);
        probe("R4 read cond ignores write", 24'h001000, 1'b0, 2'b10, 1'b0);
        probe("R12 read cond hits read next clock", 24'h001000, 1'b0, 2'b01, 1'b1);
        wr(1'b1, 32'h05);
        probe("R4 write cond ignores read", 24'h001000, 1'b0, 2'b01, 1'b0);
        probe("R4 write cond hits write", 24'h001000, 1'b0, 2'b10, 1'b1);
        wr(1'b1, 32'h07);
        probe("R4 any cond hits read", 24'h001000, 1'b0, 2'b01, 1'b1);
        probe("R4 any cond hits write", 24'h001000, 1'b0, 2'b10, 1'b1);
        probe("R4 any cond ignores fetch", 24'h001000, 1'b0, 2'b00, 1'b0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(1'b1, 32'h02);
        bus(24'h001000, 1'b0, 2'b01);
        check("R3 no request while disabled", {31'd0, irq_req}, 32'd0);
        rd(1'b1, v); check("R3 flag set while disabled", v, 32'h82);
        wr(1'b1, 32'h83);
        check("R3 request once enabled", {31'd0, irq_req}, 32'd1);
        clear_flag();
        check("R10 request drops after clear", {31'd0, irq_req}, 32'd0);
    endtask

    task automatic t_master();
        wr(1'b1, 32'h43);
        probe("R5 other master selected ignores CPU", 24'h001000, 1'b0, 2'b01, 1'b0);
        probe("R5 other master selected hits it", 24'h001000, 1'b1, 2'b01, 1'b1);
        wr(1'b1, 32'h03);
        probe("R5 CPU selected ignores other master", 24'h001000, 1'b1, 2'b01, 1'b0);
    endtask

    task automatic t_mask();
        wr(1'b0, 32'h0000_1230);
        wr(1'b1, 32'h0B);
        probe("R6 code1 hit", 24'h001231, 1'b0, 2'b01, 1'b1);
        probe("R6 code1 miss", 24'h001232, 1'b0, 2'b01, 1'b0);
        wr(1'b1, 32'h13);
        probe("R6 code2 hit", 24'h001233, 1'b0, 2'b01, 1'b1);
        probe("R6 code2 miss", 24'h001234, 1'b0, 2'b01, 1'b0);
        wr(1'b1, 32'h1B);
        probe("R6 code3 hit", 24'h00123F, 1'b0, 2'b01, 1'b1);
        probe("R6 code3 miss", 24'h001240, 1'b0, 2'b01, 1'b0);
        wr(1'b1, 32'h23);
        probe("R6 code4 hit", 24'h0012FF, 1'b0, 2'b01, 1'b1);
        probe("R6 code4 miss", 24'h001330, 1'b0, 2'b01, 1'b0);
        wr(1'b1, 32'h2B);
        probe("R6 code5 hit", 24'h001ABC, 1'b0, 2'b01, 1'b1);
        probe("R6 code5 miss", 24'h002230, 1'b0, 2'b01, 1'b0);
        wr(1'b1, 32'h33);
        probe("R6 code6 exact miss", 24'h001231, 1'b0, 2'b01, 1'b0);
        probe("R6 code6 exact hit", 24'h001230, 1'b0, 2'b01, 1'b1);
    endtask

    task automatic t_fetch();
        wr(1'b0, 32'h0000_0400);
        wr(1'b1, 32'h01);
        bus(24'h000400, 1'b0, 2'b00);
        check("R7 no flag at fetch", {31'd0, irq_req}, 32'd0);
        exe(24'h000400);
        check("R7 flag after execute", {31'd0, irq_req}, 32'd1);
        clear_flag();
        bus(24'h000400, 1'b0, 2'b00);
        exe(24'h000402);
        check("R9 other execute no hit", {31'd0, irq_req}, 32'd0);
        exe(24'h000400);
        check("R9 pending dropped", {31'd0, irq_req}, 32'd0);
        bus(24'h000400, 1'b1, 2'b00);
        exe(24'h000400);
        check("R8 fetch by other master ignored", {31'd0, irq_req}, 32'd0);
        wr(1'b1, 32'h41);
        bus(24'h000400, 1'b0, 2'b00);
        exe(24'h000400);
        check("R8 fetch cond with other master select", {31'd0, irq_req}, 32'd0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        wr(1'b0, 32'h0000_1000);
        wr(1'b1, 32'h03);
        bus(24'h001000, 1'b0, 2'b01);
        wr(1'b1, 32'h03);
        check("R10 write without read keeps flag", {31'd0, irq_req}, 32'd1);
        bus(24'h005000, 1'b0, 2'b01);
        check("R10 flag holds without matches", {31'd0, irq_req}, 32'd1);
        rd(1'b1, v);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h03;
        bus_valid = 1'b1; bus_addr = 24'h001000; bus_master = 1'b0; bus_kind = 2'b01;
        @(negedge clk);
        reg_wr = 1'b0; bus_valid = 1'b0; bus_kind = 2'b11;
        check("R11 match beats clear", {31'd0, irq_req}, 32'd1);
        clear_flag();
        rd(1'b1, v); check("R10 proper clear", v, 32'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_data_kinds();
        t_enable();
        t_master();
        t_mask();
        t_fetch();
        t_sticky();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule